// File: doc/BRIEF.md
# Ratio-Aware Peripheral Register Bridge

This block carries a single CPU register access from the fast core clock domain, through a middle bus stage, out to a slow peripheral register port. The two slower clocks are not real clocks: they are clock-enable strobes generated inside the block from a free-running phase counter on the core clock. Each stage hands the transfer on only at an edge where the matching strobe is high. The access latency therefore depends on the programmed clock ratios and on where the phase counter stands when the request arrives.

A request is accepted while the bridge is idle. A fixed three-cycle preparation period follows. The transfer then waits for the next bus-strobe edge and crosses the bus stage until a peripheral-strobe edge arrives. The peripheral port is then held for two peripheral cycles. Writes finish at that point. Reads spend two more core cycles returning data. One address window is treated as an 8-bit register region and uses only the low byte lane. All other addresses are 16 bits wide.

Top module: `periph_bridge`

## Requirements
- R1: After reset, cpu_busy, cpu_done and p_sel are all low.
- R2: Ratio codes are 0 for 1:1, 1 for 2:1, and 2 or 3 for 4:1, on both cfg_core_bus and cfg_bus_per. With a core:bus ratio cb and a bus:peripheral ratio bp, bus_stb is high in one core cycle out of every cb, and per_stb is high in one out of every cb*bp and never without bus_stb. A strobe high in a cycle qualifies the core clock edge that ends that cycle.
- R3: Number the core edges from 0, where edge 0 is the one that accepts the request. Let h be the first bus-qualified edge at or after edge 3, so h = 3+n with n from 0 to cb-1. Let b be the first peripheral-qualified edge after h, so b = h+(1+m)*cb with m from 0 to bp-1. Let p2 be the second peripheral-qualified edge after b. A write raises cpu_done in the cycle after edge p2, for a latency of (3+n) + (1+m)*cb + 2*cb*bp core cycles.
- R4: A read raises cpu_done two core edges later than a write would, in the cycle after edge p2+2. cpu_rdata holds the read data in that cycle.
- R5: p_sel is high from the cycle after edge b up to edge p2, for exactly 2*cb*bp core cycles. p_addr, p_wr and p_wdata stay constant while p_sel is high.
- R6: An address with (addr & 0xF00) == 0x300 selects the 8-bit region. The access drives p_lanes = 01 and p_wdata[15:8] = 0, and returns cpu_rdata[15:8] = 0 with the low byte taken from p_rdata[7:0].
- R7: Only one access is in flight at a time. cpu_busy is high from the cycle after acceptance until cpu_done, and is low in the cycle in which cpu_done is high. cpu_done lasts one cycle. Requests made while busy are ignored and start no port cycle.
- R8: Any other address is a 16-bit access, with p_lanes = 11, the full write data on p_wdata and the full p_rdata returned on reads.
- R9: The ratio inputs are sampled only while the bridge is idle. Changing them during an access alters neither the strobe spacing nor the latency of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_core_bus | input | 2 | Core:bus ratio code |
| cfg_bus_per | input | 2 | Bus:peripheral ratio code |
| cpu_req | input | 1 | Access request, taken when idle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Register address |
| cpu_wdata | input | DW | Write data |
| cpu_busy | output | 1 | Access in flight |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read data, valid with cpu_done on reads |
| bus_stb | output | 1 | Bus clock enable |
| per_stb | output | 1 | Peripheral clock enable |
| p_sel | output | 1 | Peripheral access cycle active |
| p_wr | output | 1 | Peripheral write |
| p_addr | output | AW | Peripheral address |
| p_wdata | output | DW | Peripheral write data |
| p_lanes | output | DW/8 | Active byte lanes |
| p_rdata | input | DW | Peripheral read data |

## Verification
The hardest situation to reach is a given pair of n and m together with a given ratio pair. Both n and m come from the position of a hidden phase counter at the moment of acceptance, which cannot be set from the ports. The stimulus covers these cases by sweeping an idle gap of 0 to 15 cycles before each request, for all nine ratio pairs and both directions, so that every starting phase is hit. Random traffic adds ratio changes in the middle of an access and stray requests while the bridge is busy. The expected edges are derived from the strobes observed at the ports.

// File: rtl/periph_bridge.sv
module periph_bridge #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter logic [AW-1:0] NARROW_BASE = 'h300,
  parameter logic [AW-1:0] NARROW_MASK = 'hF00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cfg_core_bus,
  input  logic [1:0]      cfg_bus_per,
  input  logic            cpu_req,
  input  logic            cpu_wr,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [DW-1:0]   cpu_wdata,
  output logic            cpu_busy,
  output logic            cpu_done,
  output logic [DW-1:0]   cpu_rdata,
  output logic            bus_stb,
  output logic            per_stb,
  output logic            p_sel,
  output logic            p_wr,
  output logic [AW-1:0]   p_addr,
  output logic [DW-1:0]   p_wdata,
  output logic [DW/8-1:0] p_lanes,
  input  logic [DW-1:0]   p_rdata
);
  localparam int LANES = DW / 8;

  typedef enum logic [2:0] {S_IDLE, S_PREP, S_HAND, S_BUS, S_PER, S_RET} state_t;

  function automatic logic [1:0] ratio_lg(input logic [1:0] code);
    return code[1] ? 2'd2 : {1'b0, code[0]};
  endfunction

  state_t        state;
  logic [3:0]    phase;
  logic [1:0]    cb_q, bp_q, cnt;
  logic          wr_q, narrow_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  logic [1:0] cb_lg, bp_lg;
  logic [3:0] cb_mask, bp_mask;

  assign cb_lg   = ratio_lg(cb_q);
  assign bp_lg   = ratio_lg(bp_q);
  assign cb_mask = (4'd1 << cb_lg) - 4'd1;
  assign bp_mask = (4'd1 << bp_lg) - 4'd1;
  assign bus_stb = (phase & cb_mask) == cb_mask;
  assign per_stb = bus_stb && (((phase >> cb_lg) & bp_mask) == bp_mask);

  assign cpu_busy  = state != S_IDLE;
  assign cpu_rdata = rdata_q;
  assign p_sel     = state == S_PER;
  assign p_wr      = wr_q;
  assign p_addr    = addr_q;
  assign p_wdata   = narrow_q ? {{(DW-8){1'b0}}, wdata_q[7:0]} : wdata_q;
  assign p_lanes   = narrow_q ? LANES'(1) : {LANES{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      phase    <= '0;
      cb_q     <= '0;
      bp_q     <= '0;
      cnt      <= '0;
      wr_q     <= 1'b0;
      narrow_q <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      cpu_done <= 1'b0;
    end else begin
      phase    <= phase + 4'd1;
      cpu_done <= 1'b0;
      if (state == S_IDLE) begin
        cb_q <= cfg_core_bus;
        bp_q <= cfg_bus_per;
      end
      case (state)
        S_IDLE: if (cpu_req) begin
          addr_q   <= cpu_addr;
          wr_q     <= cpu_wr;
          wdata_q  <= cpu_wdata;
          narrow_q <= (cpu_addr & NARROW_MASK) == NARROW_BASE;
          cnt      <= '0;
          state    <= S_PREP;
        end
        S_PREP: begin
          if (cnt == 2'd2) state <= bus_stb ? S_BUS : S_HAND;
          else cnt <= cnt + 2'd1;
        end
        S_HAND: if (bus_stb) state <= S_BUS;
        S_BUS: if (per_stb) begin
          cnt   <= '0;
          state <= S_PER;
        end
        S_PER: if (per_stb) begin
          if (cnt == 2'd1) begin
            cnt <= '0;
            if (wr_q) begin
              cpu_done <= 1'b1;
              state    <= S_IDLE;
            end else begin
              rdata_q <= narrow_q ? {{(DW-8){1'b0}}, p_rdata[7:0]} : p_rdata;
              state   <= S_RET;
            end
          end else cnt <= 2'd1;
        end
        S_RET: begin
          if (cnt == 2'd1) begin
            cpu_done <= 1'b1;
            state    <= S_IDLE;
          end else cnt <= cnt + 2'd1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/periph_bridge_chk.sv
module periph_bridge_chk #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_req,
  input logic            cpu_busy,
  input logic            cpu_done,
  input logic            bus_stb,
  input logic            per_stb,
  input logic            p_sel,
  input logic            p_wr,
  input logic [AW-1:0]   p_addr,
  input logic [DW-1:0]   p_wdata,
  input logic [DW/8-1:0] p_lanes
);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_busy) |=> cpu_busy);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> !cpu_busy);

  assert_per_in_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    per_stb |-> bus_stb);

  assert_sel_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    p_sel |-> cpu_busy);

  assert_sel_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    p_sel |=> (!p_sel || ($stable(p_addr) && $stable(p_wr) && $stable(p_wdata))));

  assert_sel_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (p_sel && !per_stb) |=> p_sel);

  assert_narrow_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (p_sel && p_lanes == 2'b01) |-> (p_wdata[DW-1:8] == '0));
endmodule

bind periph_bridge periph_bridge_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_busy(cpu_busy),
  .cpu_done(cpu_done), .bus_stb(bus_stb), .per_stb(per_stb), .p_sel(p_sel),
  .p_wr(p_wr), .p_addr(p_addr), .p_wdata(p_wdata), .p_lanes(p_lanes)
);

// File: tb/periph_bridge_test.sv
`timescale 1ns/1ps
module periph_bridge_test;
  logic        clk = 0, rst_n = 0;
  logic [1:0]  cfg_core_bus = 0, cfg_bus_per = 0;
  logic        cpu_req = 0, cpu_wr = 0;
  logic [11:0] cpu_addr = 0;
  logic [15:0] cpu_wdata = 0;
  logic        cpu_busy, cpu_done, bus_stb, per_stb, p_sel, p_wr;
  logic [15:0] cpu_rdata, p_wdata, p_rdata;
  logic [11:0] p_addr;
  logic [1:0]  p_lanes;
  int errs = 0, checks = 0;

  always #2 clk = ~clk;

  function automatic logic [15:0] pmodel(input logic [11:0] a);
    return {a[3:0], a[11:4]} ^ 16'hC35A;
  endfunction
  assign p_rdata = pmodel(p_addr);

  periph_bridge uut (
    .clk(clk), .rst_n(rst_n), .cfg_core_bus(cfg_core_bus), .cfg_bus_per(cfg_bus_per),
    .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_stb(bus_stb), .per_stb(per_stb), .p_sel(p_sel), .p_wr(p_wr),
    .p_addr(p_addr), .p_wdata(p_wdata), .p_lanes(p_lanes), .p_rdata(p_rdata));

  function automatic int ratio(input logic [1:0] c);
    return (c == 0) ? 1 : (c == 1) ? 2 : 4;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  bit busr[0:79], perr[0:79], selr[0:79], busyr[0:79];

  task automatic access(input bit wr, input logic [11:0] a, input logic [15:0] d,
                        input logic [1:0] cbc, input logic [1:0] bpc, input int gap,
                        input bit stray, input bit chg);
    int cb, bp, done_at, h, b, p1, p2, lat, nsel, fsel, lastb, lastp;
    bit bad_port, bad_stb, bad_busy, narrow;
    logic [15:0] rd, exp_w, exp_r;
    cb = ratio(cbc); bp = ratio(bpc);
    narrow = (a & 12'hF00) == 12'h300;
    exp_w = narrow ? {8'h00, d[7:0]} : d;
    exp_r = narrow ? {8'h00, pmodel(a)[7:0]} : pmodel(a);
    @(negedge clk);
    while (cpu_busy) @(negedge clk);
    cfg_core_bus = cbc; cfg_bus_per = bpc;
    repeat (gap + 1) @(negedge clk);
    cpu_req = 1; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    done_at = -1; bad_port = 0; rd = '0;
    for (int k = 1; k < 80 && done_at < 0; k++) begin
      @(negedge clk);
      if (k == 1) cpu_req = 0;
      if (stray && k == 2) begin cpu_req = 1; cpu_wr = ~wr; cpu_addr = a ^ 12'h0F0; end
      if (stray && k == 3) cpu_req = 0;
      if (chg && k == 4) begin cfg_core_bus = ~cbc; cfg_bus_per = ~bpc; end
      busr[k] = bus_stb; perr[k] = per_stb; selr[k] = p_sel; busyr[k] = cpu_busy;
      if (p_sel && (p_addr != a || p_wr != wr || p_wdata != exp_w ||
                    p_lanes != (narrow ? 2'b01 : 2'b11))) bad_port = 1;
      if (cpu_done) begin done_at = k; rd = cpu_rdata; end
    end
    cfg_core_bus = cbc; cfg_bus_per = bpc;
    if (done_at < 0) begin
      check(0, "R3", "no done", -1, 0);
      return;
    end
    bad_stb = 0; lastb = -1; lastp = -1;
    for (int k = 1; k < done_at; k++) begin
      if (perr[k] && !busr[k]) bad_stb = 1;
      if (busr[k]) begin if (lastb >= 0 && k - lastb != cb) bad_stb = 1; lastb = k; end
      if (perr[k]) begin if (lastp >= 0 && k - lastp != cb * bp) bad_stb = 1; lastp = k; end
    end
    check(!bad_stb, chg ? "R9" : "R2", "strobe spacing", lastb, cb);
    h = -1; b = -1; p1 = -1; p2 = -1;
    for (int k = 3; k < done_at; k++) begin
      if (h < 0) begin if (busr[k]) h = k; end
      else if (b < 0) begin if (perr[k]) b = k; end
      else if (p1 < 0) begin if (perr[k]) p1 = k; end
      else if (p2 < 0) begin if (perr[k]) p2 = k; end
    end
    lat = (p2 < 0) ? -1 : p2 + (wr ? 0 : 2);
    check(p2 > 0 && h - 3 < cb && (b - h) % cb == 0 && (b - h) / cb >= 1 &&
          (b - h) / cb <= bp && p2 - b == 2 * cb * bp,
          wr ? "R3" : "R4", "formula terms", p2 - b, 2 * cb * bp);
    check(done_at == lat + 1, wr ? "R3" : "R4", "done cycle", done_at, lat + 1);
    nsel = 0; fsel = -1;
    for (int k = 1; k <= done_at; k++) if (selr[k]) begin nsel++; if (fsel < 0) fsel = k; end
    check(nsel == 2 * cb * bp && fsel == b + 1, "R5", "p_sel cycles", nsel, 2 * cb * bp);
    check(!bad_port, narrow ? "R6" : "R8", "port fields", int'(p_wdata), int'(exp_w));
    if (!wr) check(rd == exp_r, narrow ? "R6" : "R4", "read data", int'(rd), int'(exp_r));
    bad_busy = busyr[done_at];
    for (int k = 1; k < done_at; k++) if (!busyr[k]) bad_busy = 1;
    @(negedge clk);
    check(!bad_busy && !cpu_busy && !p_sel && !cpu_done, "R7", "busy window", int'(cpu_busy), 0);
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    check(!cpu_busy && !cpu_done && !p_sel, "R1", "reset outputs", int'(cpu_busy), 0);
    rst_n = 1;
    @(negedge clk);
    check(!cpu_busy && !cpu_done && !p_sel, "R1", "after reset", int'(p_sel), 0);
    for (int cbc = 0; cbc < 3; cbc++)
      for (int bpc = 0; bpc < 3; bpc++)
        for (int g = 0; g < 16; g++)
          for (int w = 0; w < 2; w++)
            access(w[0], (g[0] ? 12'h3A5 : 12'h1C4) + 12'(g), 16'hA55A ^ 16'(g * 97),
                   cbc[1:0], bpc[1:0], g, 1'b0, 1'b0);
    access(1'b1, 12'h300, 16'hFFFF, 2'd3, 2'd3, 0, 1'b1, 1'b1);
    access(1'b0, 12'h3FF, 16'h0000, 2'd3, 2'd3, 7, 1'b1, 1'b1);
    access(1'b0, 12'hFFF, 16'h1234, 2'd0, 2'd0, 0, 1'b1, 1'b0);
    for (int i = 0; i < 150; i++) begin
      logic [11:0] a;
      a = 12'($urandom);
      if ($urandom % 10 < 3) a = {4'h3, a[7:0]};
      access(1'($urandom), a, 16'($urandom), 2'($urandom), 2'($urandom),
             int'($urandom % 21), 1'($urandom), 1'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule